// File: doc/BRIEF.md
# Synchronous Serial Clock and Frame Sampler for a UART

This block gives a UART core a clocked (synchronous) way of working, on a single system clock. It has two roles. As a slave it takes a serial clock from outside. It brings that clock and the receive data line into the system-clock domain through flop chains of equal depth, and it turns the clock into one-cycle rising-edge and falling-edge pulses. As a master it divides the system clock by an integer divisor to make its own serial clock. It drives that clock out and raises an enable so a bidirectional pad switches to output.

Frames are 8N1: one low start bit, eight data bits sent least significant bit first, and one high stop bit. In slave mode the receiver does not have a fixed sampling edge. The first serial-clock edge of either direction that finds the data line low marks the start bit, and that edge direction is used for the rest of the frame. The choice is made again for every frame. In master mode the receiver samples on rising edges of the generated clock. The transmitter shifts on falling edges of whichever serial clock is active. Received bytes come out with a one-cycle strobe, and a bad stop bit gives a one-cycle error pulse instead.

Top module: `suart_sync_uart`

## Requirements
- R1: `sck_oe` equals `master_en`. While in slave mode (`master_en` = 0), `sck_out` stays 0 from the second cycle on.
- R2: In master mode with divisor `baud_div` = N, `sck_out` toggles every N system clocks. An N of 0 is treated as 1, so the clock then toggles every cycle.
- R3: In slave mode, `sck_in` and `rxd_in` pass through synchronizer chains of the same depth. A data change made in the same system-clock cycle as a clock edge is therefore seen by that edge. Each edge pulse is one system clock wide, and a rising pulse and a falling pulse never occur together.
- R4: In slave mode, while idle, the first edge of either direction with `rxd_in` low is the start bit. The next eight edges of that same direction sample data bits 0 to 7, and the ninth samples the stop bit.
- R5: In master mode, the receiver samples the start bit, the data bits and the stop bit on rising edges of the generated clock.
- R6: When the stop bit is sampled as 1, `rx_data` takes the byte and `rx_valid` is high for exactly one cycle.
- R7: When the stop bit is sampled as 0, `rx_frame_err` pulses for one cycle and `rx_valid` stays low for that frame.
- R8: After each frame the receiver goes back to idle, and the next frame chooses its edge direction afresh.
- R9: While idle, a `tx_start` pulse loads `tx_data` and sets `tx_busy`. On the following falling edges of the active serial clock, `txd` carries a 0 start bit, then data bits 0 to 7, then a 1 stop bit. `tx_busy` clears on the eleventh falling edge. `txd` is 1 whenever the transmitter is idle.
- R10: A `tx_start` pulse that arrives while `tx_busy` is high is ignored. The frame already in progress goes out unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 selects master mode, 0 selects slave mode |
| baud_div | input | DIV_W | Half-period of the generated clock, in system clocks |
| sck_in | input | 1 | External serial clock (slave mode) |
| rxd_in | input | 1 | Serial receive data |
| tx_start | input | 1 | Pulse to start sending `tx_data` |
| tx_data | input | DATA_W | Byte to transmit |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Output enable for the bidirectional clock pad |
| txd | output | 1 | Serial transmit data, idles high |
| tx_busy | output | 1 | Transmit frame in progress |
| rx_data | output | DATA_W | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_frame_err | output | 1 | One-cycle pulse for a zero stop bit |

## Verification
In slave mode with falling-edge sampling, the receiver stores a bit and the transmitter moves to its next bit on the same resynchronized falling-edge pulse. The bench starts a transmit frame and then sends a receive frame whose start bit lands on a falling edge, so the two share every falling edge. It reads `txd` back before each rising edge and compares those ten bits, and the received byte, with values it computes itself. A second case makes a data change and a clock edge arrive in the same system-clock cycle. The bench checks that the edge still sees the new data.

// File: rtl/suart_pkg.sv
package suart_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DATA = 2'd1,
        RX_STOP = 2'd2
    } rx_state_e;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } edge_pol_e;

    // start + stop bits wrapped around each data word
    localparam int unsigned FRAME_OVERHEAD = 2;

endpackage

// File: rtl/suart_sync_edge.sv
module suart_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic rxd_raw,
    output logic rxd_s,
    output logic rise_p,
    output logic fall_p
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] rxd;
        logic              sck_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.sck      = {sync_q.sck[STAGES-2:0], sck_raw};
        sync_d.rxd      = {sync_q.rxd[STAGES-2:0], rxd_raw};
        sync_d.sck_prev = sync_q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sck      <= '0;
            sync_q.rxd      <= '1;
            sync_q.sck_prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rxd_s  = sync_q.rxd[STAGES-1];
    assign rise_p =  sync_q.sck[STAGES-1] & ~sync_q.sck_prev;
    assign fall_p = ~sync_q.sck[STAGES-1] &  sync_q.sck_prev;

endmodule

// File: rtl/suart_sck_gen.sv
module suart_sck_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             rise_p,
    output logic             fall_p
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } gen_t;

    gen_t             gen_d, gen_q;
    logic [DIV_W-1:0] limit;
    logic             wrap;

    always_comb begin
        limit = (div == '0) ? DIV_W'(1) : div;
        wrap  = run && (gen_q.cnt >= limit - DIV_W'(1));
        gen_d = gen_q;
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.sck = 1'b0;
        end else if (wrap) begin
            gen_d.cnt = '0;
            gen_d.sck = ~gen_q.sck;
        end else begin
            gen_d.cnt = gen_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.cnt <= '0;
            gen_q.sck <= 1'b0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sck    = gen_q.sck;
    assign rise_p = wrap & ~gen_q.sck;
    assign fall_p = wrap &  gen_q.sck;

endmodule

// File: rtl/suart_rx.sv
module suart_rx
    import suart_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_s,
    input  logic              rise_p,
    input  logic              fall_p,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              ferr
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_state_e         st;
        edge_pol_e         pol;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              ferr;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic hit;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.ferr  = 1'b0;
        hit        = (rx_q.pol == POL_RISE) ? rise_p : fall_p;
        unique case (rx_q.st)
            RX_IDLE: begin
                if (!rxd_s && (rise_p || fall_p)) begin
                    rx_d.st  = RX_DATA;
                    rx_d.pol = rise_p ? POL_RISE : POL_FALL;
                    rx_d.cnt = '0;
                end
            end
            RX_DATA: begin
                if (hit) begin
                    rx_d.shreg = {rxd_s, rx_q.shreg[DATA_W-1:1]};
                    if (rx_q.cnt == CNT_W'(DATA_W - 1)) begin
                        rx_d.st = RX_STOP;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CNT_W'(1);
                    end
                end
            end
            RX_STOP: begin
                if (hit) begin
                    rx_d.st = RX_IDLE;
                    if (rxd_s) begin
                        rx_d.valid = 1'b1;
                        rx_d.data  = rx_q.shreg;
                    end else begin
                        rx_d.ferr = 1'b1;
                    end
                end
            end
            default: rx_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q.st    <= RX_IDLE;
            rx_q.pol   <= POL_RISE;
            rx_q.cnt   <= '0;
            rx_q.shreg <= '0;
            rx_q.data  <= '0;
            rx_q.valid <= 1'b0;
            rx_q.ferr  <= 1'b0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign data  = rx_q.data;
    assign valid = rx_q.valid;
    assign ferr  = rx_q.ferr;

endmodule

// File: rtl/suart_tx.sv
module suart_tx
    import suart_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic              shift_p,
    output logic              txd,
    output logic              busy
);

    localparam int unsigned FRAME_W = DATA_W + FRAME_OVERHEAD;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic               txd;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] frame;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (!tx_q.busy) begin
            if (start) begin
                tx_d.busy  = 1'b1;
                tx_d.frame = {1'b1, data, 1'b0};
                tx_d.cnt   = '0;
            end
        end else if (shift_p) begin
            if (tx_q.cnt == CNT_W'(FRAME_W)) begin
                tx_d.busy = 1'b0;
                tx_d.txd  = 1'b1;
            end else begin
                tx_d.txd   = tx_q.frame[0];
                tx_d.frame = {1'b1, tx_q.frame[FRAME_W-1:1]};
                tx_d.cnt   = tx_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q.busy  <= 1'b0;
            tx_q.txd   <= 1'b1;
            tx_q.cnt   <= '0;
            tx_q.frame <= '1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign txd  = tx_q.txd;
    assign busy = tx_q.busy;

endmodule

// File: rtl/suart_sync_uart.sv
module suart_sync_uart #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              sck_in,
    input  logic              rxd_in,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              txd,
    output logic              tx_busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err
);

    logic rxd_s;
    logic s_rise, s_fall;
    logic g_rise, g_fall;
    logic rx_rise, rx_fall, tx_shift;

    suart_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_raw (sck_in),
        .rxd_raw (rxd_in),
        .rxd_s   (rxd_s),
        .rise_p  (s_rise),
        .fall_p  (s_fall)
    );

    suart_sck_gen #(
        .DIV_W (DIV_W)
    ) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (master_en),
        .div    (baud_div),
        .sck    (sck_out),
        .rise_p (g_rise),
        .fall_p (g_fall)
    );

    // master: fixed rising-edge sampling; slave: either direction, tracked per frame
    assign rx_rise  = master_en ? g_rise : s_rise;
    assign rx_fall  = master_en ? 1'b0   : s_fall;
    assign tx_shift = master_en ? g_fall : s_fall;
    assign sck_oe   = master_en;

    suart_rx #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd_s  (rxd_s),
        .rise_p (rx_rise),
        .fall_p (rx_fall),
        .data   (rx_data),
        .valid  (rx_valid),
        .ferr   (rx_frame_err)
    );

    suart_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .data    (tx_data),
        .shift_p (tx_shift),
        .txd     (txd),
        .busy    (tx_busy)
    );

endmodule

// File: rtl/suart_sync_chk.sv
module suart_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_oe,
    input logic sck_out,
    input logic s_rise,
    input logic s_fall,
    input logic rx_valid,
    input logic rx_frame_err,
    input logic tx_start,
    input logic tx_busy,
    input logic txd
);

    // R1: clock pin quiet once slave mode has held for a cycle
    assert_slave_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_oe ##1 !sck_oe) |-> !sck_out);

    // R3: edge pulses are single-cycle and mutually exclusive
    assert_rise_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_rise |=> !s_rise);
    assert_fall_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_fall |=> !s_fall);
    assert_edge_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_rise && s_fall));

    // R6: byte strobe lasts one cycle
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: framing error never coincides with a byte strobe
    assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_frame_err));
    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> !rx_frame_err);

    // R9: idle line high, and an accepted start sets busy
    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !tx_busy) |=> tx_busy);

endmodule

bind suart_sync_uart suart_sync_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_oe       (sck_oe),
    .sck_out      (sck_out),
    .s_rise       (s_rise),
    .s_fall       (s_fall),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .tx_start     (tx_start),
    .tx_busy      (tx_busy),
    .txd          (txd)
);

// File: tb/suart_sync_uart_tb.sv
module suart_sync_uart_tb;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              master_en;
    logic [DIV_W-1:0]  baud_div;
    logic              sck_drv;
    logic              rxd_drv;
    logic              loop_en;
    logic              tx_start;
    logic [DATA_W-1:0] tx_data;
    logic              sck_out, sck_oe, txd, tx_busy, rx_valid, rx_frame_err;
    logic [DATA_W-1:0] rx_data;
    logic              rxd_in;

    always #4 clk = ~clk;   // 125 MHz

    assign rxd_in = loop_en ? txd : rxd_drv;

    suart_sync_uart #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .baud_div(baud_div),
        .sck_in(sck_drv), .rxd_in(rxd_in), .tx_start(tx_start), .tx_data(tx_data),
        .sck_out(sck_out), .sck_oe(sck_oe), .txd(txd), .tx_busy(tx_busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    int n_chk = 0, n_fail = 0;
    int valid_cnt = 0, ferr_cnt = 0;
    logic [DATA_W-1:0] last_data = '0;
    bit slave_clk_seen = 0;
    logic prev_sck = 0;
    int run_len = 0, last_half = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin valid_cnt++; last_data = rx_data; end
            if (rx_frame_err) ferr_cnt++;
            if (!master_en && (sck_out || sck_oe)) slave_clk_seen = 1;
            if (master_en) begin
                if (sck_out != prev_sck) begin last_half = run_len; run_len = 1; end
                else run_len++;
            end else run_len = 0;
            prev_sck = sck_out;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_line(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one slave frame; pol_fall picks the sampling direction, same_cyc
    // changes data in the same cycle as the sampling edge.
    task automatic slave_frame(input logic [7:0] b, input logic stop_v, input bit pol_fall,
                               input bit same_cyc, output logic [9:0] line);
        logic idle_lvl;
        idle_lvl = pol_fall;
        line = '0;
        for (int i = 0; i < 10; i++) begin
            rxd_drv = (i == 0) ? 1'b0 : (i == 9) ? stop_v : b[i-1];
            if (!same_cyc) wait_clk(4);
            sck_drv = ~idle_lvl;
            wait_clk(4);
            line[i] = txd;
            if (i == 9) rxd_drv = 1'b1;
            wait_clk(4);
            sck_drv = idle_lvl;
            if (same_cyc) wait_clk(4);
        end
        wait_clk(6);
    endtask

    task automatic set_idle(input bit pol_fall);
        sck_drv = pol_fall;
        rxd_drv = 1'b1;
        wait_clk(8);
    endtask

    task automatic pulse_start(input logic [7:0] b);
        tx_data  = b;
        tx_start = 1'b1;
        wait_clk(1);
        tx_start = 1'b0;
    endtask

    task automatic wait_valid(input int base, input int limit);
        for (int k = 0; k < limit; k++) begin
            if (valid_cnt != base) break;
            wait_clk(1);
        end
    endtask

    initial begin : watchdog
        for (int k = 0; k < 150000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [9:0] line;
        logic [7:0] b;
        int base, fbase;
        void'($urandom(32'd8191));
        rst_n = 0; master_en = 0; baud_div = 4; sck_drv = 0; rxd_drv = 1;
        loop_en = 0; tx_start = 0; tx_data = '0;
        wait_clk(3);
        rst_n = 1;
        wait_clk(2);

        // reset state
        check_eq("R9 reset txd", txd, 1);
        check_eq("R9 reset busy", tx_busy, 0);
        check_eq("R6 reset valid", rx_valid, 0);
        check_eq("R1 reset oe", sck_oe, 0);
        check_eq("R1 reset sck_out", sck_out, 0);

        // R4 rising-edge frame, then R8 falling-edge frame right after
        set_idle(0);
        base = valid_cnt;
        slave_frame(8'hA5, 1'b1, 0, 0, line);
        check_eq("R4 rise frame count", valid_cnt - base, 1);
        check_eq("R4 rise frame data", last_data, 8'hA5);
        set_idle(1);
        base = valid_cnt;
        slave_frame(8'h3C, 1'b1, 1, 0, line);
        check_eq("R8 fall frame count", valid_cnt - base, 1);
        check_eq("R8 fall frame data", last_data, 8'h3C);

        // R3 data change in the same cycle as the edge, both polarities
        set_idle(0);
        base = valid_cnt;
        slave_frame(8'h96, 1'b1, 0, 1, line);
        check_eq("R3 same-cycle rise data", last_data, 8'h96);
        check_eq("R3 same-cycle rise count", valid_cnt - base, 1);
        set_idle(1);
        slave_frame(8'h69, 1'b1, 1, 1, line);
        check_eq("R3 same-cycle fall data", last_data, 8'h69);

        // R7 zero stop bit
        set_idle(0);
        base = valid_cnt; fbase = ferr_cnt;
        slave_frame(8'h55, 1'b0, 0, 0, line);
        check_eq("R7 ferr count", ferr_cnt - fbase, 1);
        check_eq("R7 no valid", valid_cnt - base, 0);
        set_idle(1);
        base = valid_cnt;
        slave_frame(8'h81, 1'b1, 1, 0, line);
        check_eq("R8 recovery after error", last_data, 8'h81);

        // R9 concurrent transmit and falling-edge receive in slave mode
        set_idle(1);
        pulse_start(8'hC3);
        check_eq("R9 busy after start", tx_busy, 1);
        base = valid_cnt;
        slave_frame(8'h5A, 1'b1, 1, 0, line);
        check_eq("R9 slave tx line", line, exp_line(8'hC3));
        check_eq("R4 concurrent rx data", last_data, 8'h5A);
        sck_drv = 0; wait_clk(4); sck_drv = 1; wait_clk(6);
        check_eq("R9 busy clears", tx_busy, 0);
        check_eq("R9 idle high", txd, 1);

        // random slave frames
        for (int n = 0; n < 10; n++) begin
            bit pf, sc;
            pf = 1'($urandom % 2);
            sc = 1'($urandom % 2);
            b  = 8'($urandom);
            set_idle(pf);
            base = valid_cnt;
            slave_frame(b, 1'b1, pf, sc, line);
            check_eq("R4 random frame data", last_data, b);
            check_eq("R6 random frame single strobe", valid_cnt - base, 1);
        end
        check_eq("R1 slave clock silent", slave_clk_seen, 0);

        // master mode loopback
        sck_drv = 0; rxd_drv = 1;
        loop_en = 1;
        for (int n = 0; n < 6; n++) begin
            int dv;
            dv = 3 + int'($urandom % 4);
            b  = 8'($urandom);
            baud_div = DIV_W'(dv);
            master_en = 1;
            wait_clk(2);
            check_eq("R1 master oe", sck_oe, 1);
            base = valid_cnt;
            pulse_start(b);
            wait_valid(base, 4000);
            check_eq("R5 master loopback data", last_data, b);
            check_eq("R2 half period", last_half, dv);
            wait_clk(4 * dv);
            check_eq("R9 master busy clears", tx_busy, 0);
            master_en = 0;
            wait_clk(4);
        end

        // R10 second start while busy
        baud_div = 4; master_en = 1;
        wait_clk(2);
        base = valid_cnt;
        pulse_start(8'h27);
        wait_clk(20);
        pulse_start(8'hD8);
        wait_valid(base, 4000);
        check_eq("R10 first frame kept", last_data, 8'h27);
        wait_clk(400);
        check_eq("R10 no second frame", valid_cnt - base, 1);

        // R2 clamp of zero divisor
        baud_div = 0;
        wait_clk(20);
        check_eq("R2 zero divisor clamp", last_half, 1);
        baud_div = 1;
        wait_clk(20);
        check_eq("R2 divisor one", last_half, 1);
        master_en = 0;
        wait_clk(3);
        check_eq("R1 back to slave sck_out", sck_out, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule